// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory that keeps its data bus busy on every cycle. Address and control are captured on a rising clock edge. The data transfer for that operation happens in the following cycle. Reads and writes may follow each other in any order with no idle cycle at a direction change.

The bidirectional data bus is split into three signals: a write-data input, a read-data output, and a drive flag that says when the memory owns the bus. Read data is flow-through: it comes straight from the array during its data cycle, with no output register. Write data is taken on the enabled edge that closes its data cycle and is committed to the array on that edge. A read issued right behind a write to the same address therefore sees the new value.

Three inputs control operation:
- An active-low clock enable freezes the whole pipeline, including a data phase already in progress.
- An active-low select lets the host issue empty cycles. An operation already in flight still finishes.
- An asynchronous active-low output enable gates the drive flag at any moment.

The default address width is kept small so that the memory stays small when elaborated with default parameters. Set `ADDR_W` to 17 for 128K x 8.

Top module: `zt_sram`

## Requirements
- R1: While reset is asserted and after its release, no operation is pending and `drive_o` is 0 until a read is issued.
- R2: On an enabled edge (`cen_n_i`=0) with `cs_n_i`=0 and `we_n_i`=1, a read of `addr_i` is captured. In the next cycle `drive_o` is 1 (if `oe_n_i`=0) and `rdata_o` equals the stored byte, read flow-through from the array.
- R3: On an enabled edge with `cs_n_i`=0 and `we_n_i`=0, a write to `addr_i` is captured. During its data cycle `drive_o` is 0. The value on `wdata_i` at the next enabled edge is stored at that address.
- R4: Reads and writes may alternate on every cycle. A read captured on the edge that commits a write to the same address returns the newly written byte.
- R5: An edge with `cen_n_i`=1 ignores every synchronous input. `drive_o` and `rdata_o` hold their values, and a pending data phase is stretched until the next enabled edge. For a stretched write, `wdata_i` is sampled only at that enabled edge.
- R6: An enabled edge with `cs_n_i`=1 starts no operation, but an operation already pending still completes on that edge. In the following cycle `drive_o` is 0.
- R7: `we_n_i` has no effect when `cs_n_i`=1. A deselected edge with `we_n_i`=0 does not change the array.
- R8: `oe_n_i`=1 forces `drive_o` to 0 and `rdata_o` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the pending read data in the same cycle.
- R9: `cs_n_i` is ignored on an edge with `cen_n_i`=1. A pending read keeps driving even if `cs_n_i` is high on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cen_n_i | input | 1 | Active-low clock enable |
| cs_n_i | input | 1 | Active-low select |
| we_n_i | input | 1 | Active-low write enable (high means read) |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, sampled at the edge ending a write's data cycle |
| rdata_o | output | DATA_W | Flow-through read data, zero when not driving |
| drive_o | output | 1 | Memory owns the data bus this cycle |

## Verification
The critical overlap is an edge that both commits a pending write and captures a new operation. Sometimes that new operation is a read of the same address. Sometimes the edge is stalled or deselected while the write waits. The bench provokes this overlap in three ways:
- a full sweep of alternating write/read pairs on every address of a 16-word configuration;
- stalls inserted between a write's capture and its commit, with a decoy value on `wdata_i`;
- deselected edges that carry a write strobe.

Each read's data cycle is compared with a shadow pattern computed arithmetically from the address.

// File: rtl/zt_pkg.sv
package zt_pkg;

    // Kind of operation held in the address/control stage.
    typedef enum logic [1:0] {
        ZT_NONE  = 2'b00,
        ZT_READ  = 2'b01,
        ZT_WRITE = 2'b10
    } zt_op_e;

    // Decode sampled control into an operation kind.
    function automatic zt_op_e zt_decode(input logic cs_n, input logic we_n);
        zt_op_e op;
        if (cs_n)       op = ZT_NONE;
        else if (we_n)  op = ZT_READ;
        else            op = ZT_WRITE;
        return op;
    endfunction

endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output zt_op_e            op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              commit_o
);

    typedef struct packed {
        zt_op_e            op;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t stage_d, stage_q;
    logic   advance;

    always_comb begin
        advance = ~cen_n_i;
        stage_d = stage_q;
        if (advance) begin
            stage_d.op = zt_decode(cs_n_i, we_n_i);
            if (!cs_n_i) begin
                stage_d.addr = addr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '{op: ZT_NONE, addr: '0};
        end else begin
            stage_q <= stage_d;
        end
    end

    // The pending write finishes on the next enabled edge.
    assign commit_o = advance && (stage_q.op == ZT_WRITE);
    assign op_o     = stage_q.op;
    assign addr_o   = stage_q.addr;

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Flow-through: no output register.
    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/zt_outmux.sv
module zt_outmux
    import zt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  zt_op_e            op_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] array_i,
    output logic              drive_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        drive_o = (op_i == ZT_READ) && !oe_n_i;
        rdata_o = drive_o ? array_i : '0;
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);

    zt_op_e            pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic              commit;
    logic [DATA_W-1:0] array_rd;

    zt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n_i  (cen_n_i),
        .cs_n_i   (cs_n_i),
        .we_n_i   (we_n_i),
        .addr_i   (addr_i),
        .op_o     (pend_op),
        .addr_o   (pend_addr),
        .commit_o (commit)
    );

    zt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .wr_en_i   (commit),
        .wr_addr_i (pend_addr),
        .wr_data_i (wdata_i),
        .rd_addr_i (pend_addr),
        .rd_data_o (array_rd)
    );

    zt_outmux #(.DATA_W(DATA_W)) u_out (
        .op_i    (pend_op),
        .oe_n_i  (oe_n_i),
        .array_i (array_rd),
        .drive_o (drive_o),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n_i,
    input logic              cs_n_i,
    input logic              we_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              drive_o
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !drive_o);                                              // R1

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n_i && !cs_n_i && we_n_i && !oe_n_i) |=> (drive_o || oe_n_i)); // R2

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n_i && !cs_n_i && !we_n_i) |=> !drive_o);                    // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n_i |=> (oe_n_i != $past(oe_n_i)) ||
                    (drive_o == $past(drive_o) && rdata_o == $past(rdata_o))); // R5

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n_i && cs_n_i) |=> !drive_o);                                // R6

    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!drive_o && rdata_o == '0));                           // R8

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen_n_i (cen_n_i),
    .cs_n_i  (cs_n_i),
    .we_n_i  (we_n_i),
    .oe_n_i  (oe_n_i),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
);

// File: tb/zt_sram_tb.sv
`timescale 1ns/100ps
module zt_sram_tb;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cen_n_i (cen_n),
        .cs_n_i  (cs_n),
        .we_n_i  (we_n),
        .oe_n_i  (oe_n),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .drive_o (drive)
    );

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'((a * 53 + 200) & 8'hFF);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; return just after the next rising edge.
    task automatic step(input int a, input logic w_n, input logic c_n,
                        input logic e_n, input logic [DW-1:0] wd);
        @(negedge clk);
        addr  = AW'(a);
        we_n  = w_n;
        cs_n  = c_n;
        cen_n = e_n;
        wdata = wd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset drive", {7'b0, drive}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1'b1, 1'b1, 1'b0, 8'h00);
        check("R1 idle after release", {7'b0, drive}, 8'h00);

        // R3: write sweep, data trails address by one cycle
        step(0, 1'b0, 1'b0, 1'b0, 8'h00);
        for (int a = 1; a < WORDS; a++) begin
            step(a, 1'b0, 1'b0, 1'b0, pat_a(a - 1));
            check("R3 no drive in write data cycle", {7'b0, drive}, 8'h00);
        end
        step(0, 1'b1, 1'b1, 1'b0, pat_a(WORDS - 1));

        // R2: read sweep, flow-through data in next cycle
        for (int a = 0; a < WORDS; a++) begin
            step(a, 1'b1, 1'b0, 1'b0, 8'h00);
            check("R2 drive", {7'b0, drive}, 8'h01);
            check("R2 read data", rdata, pat_a(a));
        end

        // R4: alternate write/read on every cycle, same address
        for (int a = 0; a < WORDS; a++) begin
            step(a, 1'b0, 1'b0, 1'b0, 8'h00);
            step(a, 1'b1, 1'b0, 1'b0, pat_b(a));
            check("R4 read right after write", rdata, pat_b(a));
        end
        step(0, 1'b1, 1'b1, 1'b0, 8'h00);

        // R5 / R9: stall during a read data phase
        step(3, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R5 read before stall", rdata, pat_b(3));
        step(5, 1'b0, 1'b0, 1'b1, 8'h11);
        check("R5 stall holds data", rdata, pat_b(3));
        check("R5 stall holds drive", {7'b0, drive}, 8'h01);
        step(5, 1'b0, 1'b1, 1'b1, 8'h11);
        check("R9 select ignored while stalled", {7'b0, drive}, 8'h01);
        step(0, 1'b1, 1'b1, 1'b0, 8'h11);
        check("R6 deselect ends read", {7'b0, drive}, 8'h00);
        step(5, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R5 stalled write strobe ignored", rdata, pat_b(5));

        // R5: stall during a write data phase, decoy data while stalled
        step(6, 1'b0, 1'b0, 1'b0, 8'h00);
        step(0, 1'b1, 1'b0, 1'b1, 8'hAA);
        step(0, 1'b1, 1'b1, 1'b0, 8'h5B);
        step(6, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R5 write sampled at enabled edge", rdata, 8'h5B);

        // R6 / R7: deselect completes pending op, starts none
        step(2, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R6 pending read", rdata, pat_b(2));
        step(9, 1'b0, 1'b1, 1'b0, 8'hEE);
        check("R6 bus released", {7'b0, drive}, 8'h00);
        step(0, 1'b1, 1'b1, 1'b0, 8'hEE);
        step(9, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R7 deselected write strobe ignored", rdata, pat_b(9));
        step(4, 1'b0, 1'b0, 1'b0, 8'h00);
        step(0, 1'b1, 1'b1, 1'b0, 8'h77);
        check("R6 idle after deselect", {7'b0, drive}, 8'h00);
        step(4, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R6 pending write completed", rdata, 8'h77);

        // R8: asynchronous output enable
        step(1, 1'b1, 1'b0, 1'b0, 8'h00);
        oe_n = 1'b1;
        #0.5;
        check("R8 oe high releases bus", {7'b0, drive}, 8'h00);
        check("R8 oe high zero data", rdata, 8'h00);
        oe_n = 1'b0;
        #0.5;
        check("R8 oe low restores data", rdata, pat_b(1));
        step(0, 1'b1, 1'b1, 1'b0, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule